// File: doc/BRIEF.md
# Compare-Match PWM Output Channel

This block is one output channel hung off a free-running 16-bit timer. It holds a 16-bit compare value and drives one output pin. When the compare function is switched on, the pin is set high in the cycle after the timer count equals the stored value. It is cleared in the cycle after the timer reports an overflow. Writing the compare value therefore sets the duty cycle of a PWM waveform with 16-bit resolution. Each match also sets a sticky interrupt request, which software clears.

With the compare function switched off, the pin is an ordinary port bit. It shows whatever software last wrote to the channel's port latch. While the compare function is on, that latch neither drives the pin nor accepts writes. The timer itself lives outside the block. The block sees the count, a one-cycle overflow pulse and the register write strobes.

The asynchronous active-low reset is released through a two-stage synchronizer. All register effects described below are counted from the clock edge that follows the synchronized release.

Top module: `cmp_pwm_channel`

## Requirements
- R1: After reset, the pin and the interrupt request are low, the compare function is off and the stored compare value is zero.
- R2: With the compare function on, the pin is high in the cycle after a clock edge at which all 16 bits of the timer count equal the compare value. A count that differs in any single bit, including bit 15, does not match.
- R3: With the compare function on, the pin is low in the cycle after a clock edge at which the overflow input was high.
- R4: If a match and an overflow arrive at the same clock edge while the compare function is on, the pin goes low.
- R5: While the compare function is on, a port-latch write changes neither the pin nor the stored latch value. After the function is switched off, the pin shows the value written before it was switched on.
- R6: With the compare function off, the pin equals the last value written to the port latch, from the cycle after the write.
- R7: A match while the compare function is on sets the interrupt request in the next cycle. The request stays high until a clear strobe arrives. A match at the same edge as a clear wins over the clear.
- R8: A compare-value write is used for matching from the clock edge after the write edge onward.
- R9: While the compare function is off, matches set no interrupt request. The compare output state is held low, so the pin starts low once the function is switched on, until the first match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tmr_cnt_i | input | 16 | Current timer count |
| tmr_ovf_i | input | 1 | One-cycle timer overflow pulse |
| cval_we_i | input | 1 | Compare value write strobe |
| cval_wdata_i | input | 16 | Compare value write data |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 1 | Compare function on (1) / off (0) |
| plat_we_i | input | 1 | Port latch write strobe |
| plat_wdata_i | input | 1 | Port latch write data |
| irq_clr_i | input | 1 | Clear strobe for the match request |
| pin_o | output | 1 | Output pin |
| irq_o | output | 1 | Sticky match interrupt request |

## Verification
Random timer counts are biased towards the stored compare value. This makes matches, overflows, mode switches and latch writes collide often, and it separates a correct set/clear priority from an inverted one. A directed count that differs from the compare value only in bit 15 shows whether the compare really spans the full width. A match placed on the same edge as an overflow shows whether the overflow wins. Latch writes made while the function is on, followed by switching the function off, show whether those writes were blocked or only hidden. A compare-value write followed at once by the new count shows whether the new value takes effect on the next edge.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic {
    SRC_PORT = 1'b0,
    SRC_CMP  = 1'b1
  } pin_src_e;

  typedef struct packed {
    logic set;
    logic clr;
  } flag_evt_t;
endpackage

// File: rtl/cmp_rst_sync.sv
module cmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/cmp_match_det.sv
module cmp_match_det #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tmr_cnt_i,
  input  logic             cval_we_i,
  input  logic [CNT_W-1:0] cval_wdata_i,
  output logic             match_o
);
  logic [CNT_W-1:0] cval_q;
  logic [CNT_W-1:0] cval_d;
  logic [CNT_W-1:0] diff;

  always_comb begin
    cval_d = cval_q;
    if (cval_we_i) cval_d = cval_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cval_q <= '0;
    else         cval_q <= cval_d;
  end

  assign diff    = tmr_cnt_i ^ cval_q;
  assign match_o = ~|diff;

  // R8: a written value is the one compared from the next edge on
  a_r8_new_value_used: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cval_we_i |=> (cval_q == $past(cval_wdata_i)));
endmodule

// File: rtl/cmp_out_ctrl.sv
module cmp_out_ctrl
  import cmp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_en_i,
  input  logic match_i,
  input  logic ovf_i,
  input  logic plat_we_i,
  input  logic plat_wdata_i,
  output logic pin_o
);
  logic     cmp_q, cmp_d;
  logic     plat_q, plat_d;
  pin_src_e src;

  always_comb begin
    cmp_d = cmp_q;
    if (!cmp_en_i)    cmp_d = 1'b0;
    else if (ovf_i)   cmp_d = 1'b0;
    else if (match_i) cmp_d = 1'b1;
  end

  always_comb begin
    plat_d = plat_q;
    if (plat_we_i && !cmp_en_i) plat_d = plat_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= 1'b0;
      plat_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      plat_q <= plat_d;
    end
  end

  assign src   = cmp_en_i ? SRC_CMP : SRC_PORT;
  assign pin_o = (src == SRC_CMP) ? cmp_q : plat_q;

  // R2
  a_r2_match_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && match_i && !ovf_i) |=> cmp_q);
  // R3, R4
  a_r3_ovf_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && ovf_i) |=> !cmp_q);
  // R5
  a_r5_latch_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en_i |=> $stable(plat_q));
  // R9
  a_r9_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_en_i |=> !cmp_q);
endmodule

// File: rtl/cmp_irq_flag.sv
module cmp_irq_flag
  import cmp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_en_i,
  input  logic match_i,
  input  logic clr_i,
  output logic irq_o
);
  flag_evt_t evt;
  logic      flag_q, flag_d;

  always_comb begin
    evt.set = cmp_en_i & match_i;
    evt.clr = clr_i;
    flag_d  = flag_q;
    if (evt.set)      flag_d = 1'b1;
    else if (evt.clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign irq_o = flag_q;

  // R7
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && match_i) |=> irq_o);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
  // R9
  a_r9_no_set_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_en_i && !irq_o) |=> !irq_o);
endmodule

// File: rtl/cmp_pwm_channel.sv
module cmp_pwm_channel #(
  parameter int CNT_W    = 16,
  parameter int SYNC_STG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tmr_cnt_i,
  input  logic             tmr_ovf_i,
  input  logic             cval_we_i,
  input  logic [CNT_W-1:0] cval_wdata_i,
  input  logic             ctl_we_i,
  input  logic             ctl_wdata_i,
  input  logic             plat_we_i,
  input  logic             plat_wdata_i,
  input  logic             irq_clr_i,
  output logic             pin_o,
  output logic             irq_o
);
  logic rst_n;
  logic match;
  logic en_q, en_d;

  cmp_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  always_comb begin
    en_d = en_q;
    if (ctl_we_i) en_d = ctl_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  cmp_match_det #(.CNT_W(CNT_W)) u_det (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .tmr_cnt_i    (tmr_cnt_i),
    .cval_we_i    (cval_we_i),
    .cval_wdata_i (cval_wdata_i),
    .match_o      (match)
  );

  cmp_out_ctrl u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .cmp_en_i     (en_q),
    .match_i      (match),
    .ovf_i        (tmr_ovf_i),
    .plat_we_i    (plat_we_i),
    .plat_wdata_i (plat_wdata_i),
    .pin_o        (pin_o)
  );

  cmp_irq_flag u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .cmp_en_i (en_q),
    .match_i  (match),
    .clr_i    (irq_clr_i),
    .irq_o    (irq_o)
  );

  // R1: in the first cycle after reset release, both outputs are low
  a_r1_reset_low: assert property (@(posedge clk_i)
    $rose(rst_n) |-> (!pin_o && !irq_o));
endmodule

// File: tb/sim_cmp_pwm_channel.sv
`timescale 1ns/1ps
module sim_cmp_pwm_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [15:0] cnt = '0;
  logic        ovf = 1'b0, cwr = 1'b0, mwr = 1'b0, md = 1'b0;
  logic        lwr = 1'b0, ld = 1'b0, clr = 1'b0;
  logic [15:0] cd = '0;
  logic        pin, irq;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_cmp;
  logic        m_mode, m_cmpo, m_sw, m_flag;
  string       req;

  always #2.5 clk = ~clk;

  cmp_pwm_channel u0 (
    .clk_i(clk), .rst_ni(rst_n), .tmr_cnt_i(cnt), .tmr_ovf_i(ovf),
    .cval_we_i(cwr), .cval_wdata_i(cd), .ctl_we_i(mwr), .ctl_wdata_i(md),
    .plat_we_i(lwr), .plat_wdata_i(ld), .irq_clr_i(clr),
    .pin_o(pin), .irq_o(irq)
  );

  function automatic logic exp_pin();
    return m_mode ? m_cmpo : m_sw;
  endfunction

  task automatic chk(input string r, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic [15:0] c, input logic o, input logic cw, input logic [15:0] cdat,
                      input logic mw, input logic mdat, input logic lw, input logic ldat,
                      input logic cl);
    logic hit;
    @(negedge clk);
    chk(req, pin, exp_pin(), "pin");
    chk(req, irq, m_flag, "irq");
    cnt = c; ovf = o; cwr = cw; cd = cdat; mwr = mw; md = mdat; lwr = lw; ld = ldat; clr = cl;
    @(posedge clk);
    hit = (c == m_cmp);
    m_flag = (m_mode && hit) ? 1'b1 : (cl ? 1'b0 : m_flag);
    m_cmpo = !m_mode ? 1'b0 : (o ? 1'b0 : (hit ? 1'b1 : m_cmpo));
    if (!m_mode && lw) m_sw = ldat;
    if (mw) m_mode = mdat;
    if (cw) m_cmp = cdat;
  endtask

  task automatic idle(input logic [15:0] c);
    step(c, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cmp = '0; m_mode = 1'b0; m_cmpo = 1'b0; m_sw = 1'b0; m_flag = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: outputs low; zero compare value matches count 0 once enabled
    req = "R1";
    idle(16'h1234);
    step(16'h1234, 1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(16'h0000);
    idle(16'h0001);
    chk("R1", pin, 1'b1, "pin after count 0 match");

    // R3: overflow clears pin
    req = "R3";
    step(16'h0005, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(16'h0006);
    chk("R3", pin, 1'b0, "pin after overflow");

    // R8 + R2: new compare value, then MSB-only difference, then exact match
    req = "R8";
    step(16'h0007, 1'b0, 1'b1, 16'h8123, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(16'h8123);
    idle(16'h8124);
    chk("R8", pin, 1'b1, "pin after match on new value");
    step(16'h0, 1'b1, 1'b1, 16'hA5A5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    req = "R2";
    idle(16'h25A5);
    idle(16'h25A5);
    chk("R2", pin, 1'b0, "pin with bit 15 differing");
    idle(16'hA5A5);
    idle(16'h0000);
    chk("R2", pin, 1'b1, "pin after exact match");

    // R4: match and overflow together
    req = "R4";
    step(16'hA5A5, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(16'h0001);
    chk("R4", pin, 1'b0, "pin when overflow meets match");

    // R7: sticky request; set beats clear
    req = "R7";
    idle(16'h0002);
    chk("R7", irq, 1'b1, "irq held");
    step(16'hA5A5, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(16'h0003);
    chk("R7", irq, 1'b1, "irq when set meets clear");
    step(16'h0003, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(16'h0004);
    chk("R7", irq, 1'b0, "irq after clear");

    // R6 then R5: latch write while off, writes ignored while on
    req = "R6";
    step(16'h0, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(16'h0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    idle(16'h0);
    chk("R6", pin, 1'b1, "pin follows latch");
    req = "R5";
    step(16'h0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(16'h0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    idle(16'h0);
    chk("R5", pin, 1'b0, "pin unaffected by latch write");
    step(16'h0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(16'h0);
    chk("R5", pin, 1'b1, "latch kept pre-enable value");

    // R9: matches while off set nothing; pin starts low on enable
    req = "R9";
    step(16'h0, 1'b0, 1'b1, 16'h0040, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(16'h0040);
    idle(16'h0041);
    chk("R9", irq, 1'b0, "irq from match while off");
    step(16'h0041, 1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(16'h0042);
    chk("R9", pin, 1'b0, "pin low on enable");

    // random mix covering R2-R9
    req = "R2-mix";
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] c;
      c = ($urandom % 3 == 0) ? m_cmp : 16'($urandom);
      step(c, ($urandom % 7) == 0, ($urandom % 11) == 0, 16'($urandom % 8),
           ($urandom % 13) == 0, 1'($urandom), ($urandom % 5) == 0, 1'($urandom),
           ($urandom % 6) == 0);
      if (i == 0) c = c;
    end
    idle(16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule